// File: doc/BRIEF.md
# Run-Mode Clock Source Switching Controller

This block decides which of three oscillators drives a small microcontroller's system clock: the primary oscillator (optionally multiplied by a PLL), a low-frequency secondary oscillator, or the internal oscillator block. Software writes a two-bit source code and a frequency code for the internal block. Each change of source is run as a sequence. First the block waits until the new source can be used. It then synchronises for two cycles, holds the output clock gated low for one cycle, and only then moves the mux.

A move back to the primary source has extra steps. The block turns the primary oscillator on and counts its start-up cycles, which arrive as one-cycle ticks. When the PLL is enabled, a lock interval follows the count. A status flag goes high only once the primary path really drives the clock. It drops, and the primary oscillator is turned off, when another source takes over. Analog oscillators are modelled as ready and tick inputs. The frequency code for the internal block takes effect at once, with no switch sequence.

Top module: `clock_switch_ctrl`

## Requirements
- R1: Source code decoding is as follows. `sel_src[1]`=1 selects the internal block, shown as code 2 on `src_active`, whatever the value of `sel_src[0]`. `sel_src`=00 selects the primary source (code 0). `sel_src`=01 selects the secondary source (code 1).
- R2: When the secondary or internal source takes over, `pri_osc_en` and `osc_stable` are both 0 in that same cycle.
- R3: A write updates `int_freq` to `sel_freq` on the next edge. It never drops `gate_on` and never starts a switch.
- R4: The old source keeps driving, with `gate_on`=1, until the target is ready. From the edge that samples readiness, `gate_on` reads 0 after the third edge and the new source is active after the fourth.
- R5: A switch to the primary source needs OST_CYCLES `pri_tick` pulses (1024 by default) before it counts as ready. Those pulses are counted only after the switch has begun.
- R6: With `pll_en`=1, a further PLL_CYCLES clock cycles of lock delay follow the start-up count before the handover begins.
- R7: `osc_stable` rises only in the cycle the primary source takes over. It is 1 only while `src_active`=0.
- R8: A return to the primary source always runs the full start-up count, whichever source was active before.
- R9: `src_active` changes only after a cycle with `gate_on`=0. Once running, `gate_on` is low for exactly one cycle per switch.
- R10: A code written during a switch does not disturb that switch. After it completes, the most recently written code is carried out.
- R11: After reset, `src_active`=0, `gate_on`=0, `osc_stable`=0 and `pri_osc_en`=1, and the start-up count runs.
- R12: Writing a code that decodes to the active source causes no switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the select fields |
| sel_src | input | 2 | Source code |
| sel_freq | input | FREQ_W | Internal block frequency code |
| pll_en | input | 1 | Insert PLL lock delay on a primary switch |
| pri_tick | input | 1 | One pulse per primary oscillator cycle |
| sec_ready | input | 1 | Secondary oscillator running |
| int_ready | input | 1 | Internal oscillator running |
| src_active | output | 2 | Source driving the clock (0 pri, 1 sec, 2 int) |
| gate_on | output | 1 | Output clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| osc_stable | output | 1 | Primary path stable and driving the clock |
| int_freq | output | FREQ_W | Active internal frequency code |

## Verification
The bound checker watches, on every cycle, the cycle-level relations of the block. It confirms that the mux never moves without a preceding gated-low cycle and that the gate drops for only one cycle. It confirms that the status flag never stands while a non-primary source is active, that a takeover by a non-primary source clears the enable and the flag together, and that frequency writes land on the next edge. The exact lengths of the start-up count and the lock delay, the four-edge handover latency, the queuing of a write made mid-switch, and the absence of a switch on a redundant write can be shown only by the directed scenarios, which count edges from a known stimulus.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_OST,
    ST_LOCK,
    ST_WAITRDY,
    ST_SYNC1,
    ST_SYNC2,
    ST_GATE
  } st_e;

  // upper code bit wins; lower bit matters only when upper is clear
  function automatic src_e decode_src(input logic [1:0] code);
    if (code[1])      return SRC_INT;
    else if (code[0]) return SRC_SEC;
    else              return SRC_PRI;
  endfunction
endpackage

// File: rtl/clksw_req.sv
module clksw_req
  import clksw_pkg::*;
#(
  parameter int FREQ_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        src_code,
  input  logic [FREQ_W-1:0] freq_code,
  output src_e              req_src,
  output logic [FREQ_W-1:0] freq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_src <= SRC_PRI;
      freq_q  <= '0;
    end else if (wr) begin
      req_src <= decode_src(src_code);
      freq_q  <= freq_code;
    end
  end
endmodule

// File: rtl/clksw_timer.sv
module clksw_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (done)     cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clock_switch_ctrl.sv
module clock_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int FREQ_W     = 3,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_CYCLES = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [1:0]        sel_src,
  input  logic [FREQ_W-1:0] sel_freq,
  input  logic              pll_en,
  input  logic              pri_tick,
  input  logic              sec_ready,
  input  logic              int_ready,
  output logic [1:0]        src_active,
  output logic              gate_on,
  output logic              pri_osc_en,
  output logic              osc_stable,
  output logic [FREQ_W-1:0] int_freq
);
  st_e  st;
  src_e req_src, tgt, cur;
  logic ost_done, lock_done, tgt_rdy;

  clksw_req #(.FREQ_W(FREQ_W)) u_req (
    .clk(clk), .rst(rst), .wr(sel_wr), .src_code(sel_src),
    .freq_code(sel_freq), .req_src(req_src), .freq_q(int_freq)
  );

  clksw_timer #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst(rst), .run(st == ST_OST), .tick(pri_tick), .done(ost_done)
  );

  clksw_timer #(.LIMIT(PLL_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .run(st == ST_LOCK), .tick(1'b1), .done(lock_done)
  );

  assign tgt_rdy    = (tgt == SRC_SEC) ? sec_ready : int_ready;
  assign src_active = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OST;
      tgt        <= SRC_PRI;
      cur        <= SRC_PRI;
      gate_on    <= 1'b0;
      osc_stable <= 1'b0;
      pri_osc_en <= 1'b1;
    end else begin
      case (st)
        ST_RUN: begin
          if (req_src != cur) begin
            tgt <= req_src;
            if (req_src == SRC_PRI) begin
              pri_osc_en <= 1'b1;
              st         <= ST_OST;
            end else begin
              st <= ST_WAITRDY;
            end
          end
        end
        ST_OST:     if (ost_done)  st <= pll_en ? ST_LOCK : ST_SYNC1;
        ST_LOCK:    if (lock_done) st <= ST_SYNC1;
        ST_WAITRDY: if (tgt_rdy)   st <= ST_SYNC1;
        ST_SYNC1:   st <= ST_SYNC2;
        ST_SYNC2: begin
          gate_on <= 1'b0;
          st      <= ST_GATE;
        end
        ST_GATE: begin
          cur     <= tgt;
          gate_on <= 1'b1;
          st      <= ST_RUN;
          if (tgt == SRC_PRI) begin
            osc_stable <= 1'b1;
          end else begin
            osc_stable <= 1'b0;
            pri_osc_en <= 1'b0;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker #(
  parameter int FREQ_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_wr,
  input logic [FREQ_W-1:0] sel_freq,
  input logic [1:0]        src_active,
  input logic              gate_on,
  input logic              pri_osc_en,
  input logic              osc_stable,
  input logic [FREQ_W-1:0] int_freq
);
  // R9: the mux moves only after a gated-low cycle
  a_r9_gate_before_move: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_active) |-> !$past(gate_on));

  // R9: the gate stays low for one cycle only once running
  a_r9_single_low: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_on) |=> gate_on);

  // R7: the flag needs the primary source active
  a_r7_stable_on_pri: assert property (@(posedge clk) disable iff (rst)
    osc_stable |-> (src_active == 2'd0) && pri_osc_en);

  // R2: takeover by a non-primary source clears enable and flag together
  a_r2_leave_primary: assert property (@(posedge clk) disable iff (rst)
    ($rose(src_active == 2'd2) || $rose(src_active == 2'd1)) |-> !pri_osc_en && !osc_stable);

  // R3: frequency code lands on the next edge
  a_r3_freq_next: assert property (@(posedge clk) disable iff (rst)
    $past(sel_wr && !rst) |-> int_freq == $past(sel_freq));

  // R7: the flag rises only together with the gate returning
  a_r7_rise_at_handover: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_stable) |-> $rose(gate_on));
endmodule

bind clock_switch_ctrl clksw_checker #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_freq(sel_freq),
  .src_active(src_active), .gate_on(gate_on), .pri_osc_en(pri_osc_en),
  .osc_stable(osc_stable), .int_freq(int_freq)
);

// File: tb/clock_switch_ctrl_bench.sv
module clock_switch_ctrl_bench;
  localparam int FW  = 3;
  localparam int OST = 1024;
  localparam int PLL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_wr = 1'b0;
  logic [1:0] sel_src = 2'd0;
  logic [FW-1:0] sel_freq = '0;
  logic pll_en = 1'b0, pri_tick = 1'b0, sec_ready = 1'b0, int_ready = 1'b0;
  logic [1:0] src_active;
  logic gate_on, pri_osc_en, osc_stable;
  logic [FW-1:0] int_freq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clock_switch_ctrl #(.FREQ_W(FW), .OST_CYCLES(OST), .PLL_CYCLES(PLL)) u_clock_switch_ctrl (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_src(sel_src), .sel_freq(sel_freq),
    .pll_en(pll_en), .pri_tick(pri_tick), .sec_ready(sec_ready), .int_ready(int_ready),
    .src_active(src_active), .gate_on(gate_on), .pri_osc_en(pri_osc_en),
    .osc_stable(osc_stable), .int_freq(int_freq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [FW-1:0] f);
    sel_src = s; sel_freq = f; sel_wr = 1'b1;
    step(1);
    sel_wr = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R11", "src", src_active, 0);
    chk("R11", "gate", gate_on, 0);
    chk("R11", "stable", osc_stable, 0);
    chk("R11", "pri_en", pri_osc_en, 1);
  endtask

  task automatic t_startup;
    for (int i = 0; i < OST - 1; i++) begin
      pri_tick = 1'b1; step(1);
      pri_tick = 1'b0; step(1);
    end
    step(10);
    chk("R5", "stable after 1023 ticks", osc_stable, 0);
    pri_tick = 1'b1; step(1);
    pri_tick = 1'b0; step(2);
    chk("R4", "stable two edges after ready", osc_stable, 0);
    step(1);
    chk("R7", "stable at takeover", osc_stable, 1);
    chk("R9", "gate on at takeover", gate_on, 1);
    chk("R11", "src primary", src_active, 0);
  endtask

  task automatic t_same;
    do_write(2'b00, 3'd0);
    step(6);
    chk("R12", "src", src_active, 0);
    chk("R12", "gate", gate_on, 1);
    chk("R12", "stable", osc_stable, 1);
  endtask

  task automatic t_to_int;
    do_write(2'b11, 3'd5);
    chk("R3", "freq next edge", int_freq, 5);
    step(10);
    chk("R4", "old source held", src_active, 0);
    chk("R4", "gate held", gate_on, 1);
    chk("R4", "pri still on", pri_osc_en, 1);
    int_ready = 1'b1;
    step(2);
    chk("R4", "gate after 2 edges", gate_on, 1);
    step(1);
    chk("R9", "gate low third edge", gate_on, 0);
    chk("R9", "src unchanged while gated", src_active, 0);
    step(1);
    chk("R1", "code 11 is internal", src_active, 2);
    chk("R2", "pri off", pri_osc_en, 0);
    chk("R2", "stable cleared", osc_stable, 0);
    chk("R9", "gate back on", gate_on, 1);
  endtask

  task automatic t_freq;
    int low = 0;
    do_write(2'b10, 3'd1);
    chk("R3", "freq updated", int_freq, 1);
    for (int i = 0; i < 6; i++) begin
      if (!gate_on) low++;
      step(1);
    end
    chk("R3", "no gate drop", low, 0);
    chk("R1", "code 10 same source", src_active, 2);
  endtask

  task automatic t_pll;
    pll_en = 1'b1; pri_tick = 1'b1;
    do_write(2'b00, 3'd1);
    step(1 + OST + 3);
    chk("R6", "no takeover without lock", src_active, 2);
    chk("R8", "pri enabled during count", pri_osc_en, 1);
    step(PLL - 1);
    chk("R6", "gated before takeover", gate_on, 0);
    chk("R7", "stable still low", osc_stable, 0);
    step(1);
    chk("R6", "src after lock", src_active, 0);
    chk("R7", "stable set", osc_stable, 1);
    pri_tick = 1'b0; pll_en = 1'b0;
  endtask

  task automatic t_sec;
    sec_ready = 1'b1;
    do_write(2'b01, 3'd1);
    step(5);
    chk("R1", "code 01 secondary", src_active, 1);
    chk("R2", "pri off", pri_osc_en, 0);
    chk("R2", "stable cleared", osc_stable, 0);
  endtask

  task automatic t_queue;
    int n = 0;
    pri_tick = 1'b1;
    do_write(2'b00, 3'd1);
    step(5);
    do_write(2'b10, 3'd2);
    while (src_active == 2'd1 && n < 3000) begin step(1); n++; end
    chk("R10", "first move to primary", src_active, 0);
    chk("R10", "primary stable", osc_stable, 1);
    n = 0;
    while (src_active == 2'd0 && n < 40) begin step(1); n++; end
    chk("R10", "then internal", src_active, 2);
    pri_tick = 1'b0;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_same();
    t_to_int();
    t_freq();
    t_pll();
    t_sec();
    t_queue();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule